// File: doc/BRIEF.md
# Bus Turnaround Delay Timer

This block sits beside an external memory access engine and decides when the next access may begin after the previous one has ended. When a read finishes, the device that drove the shared data bus may still be releasing it. Starting the next access at once, especially a write that drives the bus, could then cause contention. Each chip-select is given its own 4-bit gap length, counted in functional-clock cycles. When a read to a chip-select with a nonzero gap ends, the block withholds its ready output for exactly that many cycles. While that gap runs, the external buffer direction stays at input and bus keeping stays off.

When the gap expires, the block switches the buffer direction to output and turns bus keeping on in the same cycle. It also raises ready again. A write, or a read to a chip-select whose gap is zero, inserts no delay. A requester holds `req` high until `start` is granted. A request raised during a gap is therefore only delayed, never lost.

The controller has three states:
- `ST_IDLE`: the state after reset. Ready is high, direction is output and bus keeping is off.
- `ST_TURN`: the gap is counting. Ready is low, direction is input and bus keeping is off.
- `ST_KEEP`: the bus is settled. Ready is high, direction is output and bus keeping is on.

The transitions are:
- `IDLE→TURN` and `KEEP→TURN`: a read with a nonzero gap ends.
- `IDLE→KEEP` and `KEEP→KEEP`: a write ends, or a read with a zero gap ends.
- `TURN→TURN`: the gap is still counting, or a new read with a nonzero gap ends and reloads it.
- `TURN→KEEP`: the last gap cycle passes.

Top module: `bus_turnaround_gap`

## Requirements
- R1: After reset, `ready`=1, `dir_out`=1 and `bus_keep`=0.
- R2: If `acc_end` is sampled high with `end_rd`=1 and the selected gap N is nonzero, `ready` is 0 for exactly N cycles, starting in the cycle after `acc_end`.
- R3: While `ready` is 0, `dir_out` is 0 (input) and `bus_keep` is 0.
- R4: In the first cycle after a gap ends, `ready`, `dir_out` and `bus_keep` are all 1.
- R5: After `acc_end` with `end_rd`=0 (a write), the next cycle has `ready`=1, `dir_out`=1 and `bus_keep`=1, whatever the gap of that chip-select.
- R6: After a read to a chip-select whose gap is 0, the next cycle has `ready`=1, `dir_out`=1 and `bus_keep`=1.
- R7: `start` is high only when `req` and `ready` are both high. A request held through a gap is granted in the first cycle after the gap ends.
- R8: The gap for chip-select k is `turn_cnt[k*4 +: 4]`, selected by `end_cs`. Different chip-selects give different gap lengths.
- R9: The maximum gap of 15 yields exactly 15 cycles with `ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_end | input | 1 | One-cycle pulse when the chip-select or output-enable of an access deasserts |
| end_cs | input | 3 | Chip-select of the access that ended |
| end_rd | input | 1 | 1 if the ended access was a read |
| turn_cnt | input | 32 | Per-chip-select gap lengths, 4 bits each, chip-select k at bits k*4+3..k*4 |
| req | input | 1 | Next access request, held until granted |
| start | output | 1 | Grant: the next access may begin this cycle |
| ready | output | 1 | High when no gap is running |
| dir_out | output | 1 | Buffer direction, 1 = output, 0 = input |
| bus_keep | output | 1 | Bus keeper enable |

## Verification
The hardest case is a request that is already pending when a long gap begins. The grant must appear in exactly the first cycle after the gap, not one cycle early or late. The stimulus reaches this case by raising `req` in the same cycle as a read-end pulse for a chip-select with a gap of 3. It then samples `start` at every falling edge until the grant appears. Separate scenarios use the maximum gap of 15 and chip-selects with unequal gaps, which exposes errors in the gap selection and off-by-one errors in the count.

// File: rtl/bta_pkg.sv
package bta_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TURN = 2'd1,
        ST_KEEP = 2'd2
    } bta_state_t;
endpackage

// File: rtl/bta_count_sel.sv
module bta_count_sel #(
    parameter int NUM_CS = 8,
    parameter int CNT_W  = 4,
    localparam int CS_W  = $clog2(NUM_CS)
) (
    input  logic [NUM_CS*CNT_W-1:0] turn_cnt,
    input  logic [CS_W-1:0]         cs,
    output logic [CNT_W-1:0]        gap
);
    logic [CNT_W-1:0] slice [NUM_CS];

    for (genvar k = 0; k < NUM_CS; k++) begin : g_slice
        assign slice[k] = turn_cnt[k*CNT_W +: CNT_W];
    end

    assign gap = slice[cs];
endmodule

// File: rtl/bta_timer.sv
module bta_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/bus_turnaround_gap.sv
module bus_turnaround_gap
    import bta_pkg::*;
#(
    parameter int NUM_CS = 8,
    parameter int CNT_W  = 4,
    localparam int CS_W  = $clog2(NUM_CS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_end,
    input  logic [CS_W-1:0]         end_cs,
    input  logic                    end_rd,
    input  logic [NUM_CS*CNT_W-1:0] turn_cnt,
    input  logic                    req,
    output logic                    start,
    output logic                    ready,
    output logic                    dir_out,
    output logic                    bus_keep
);
    bta_state_t       state_q, state_d;
    logic [CNT_W-1:0] sel_gap;
    logic             gap_load;
    logic             gap_last;

    bta_count_sel #(.NUM_CS(NUM_CS), .CNT_W(CNT_W)) u_sel (
        .turn_cnt (turn_cnt),
        .cs       (end_cs),
        .gap      (sel_gap)
    );

    assign gap_load = acc_end && end_rd && (sel_gap != '0);

    bta_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (sel_gap),
        .last     (gap_last)
    );

    always_comb begin
        state_d = state_q;
        if (gap_load)
            state_d = ST_TURN;
        else if (acc_end)
            state_d = ST_KEEP;
        else if (state_q == ST_TURN && gap_last)
            state_d = ST_KEEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        ready    = 1'b1;
        dir_out  = 1'b1;
        bus_keep = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ready    = 1'b1;
                dir_out  = 1'b1;
                bus_keep = 1'b0;
            end
            ST_TURN: begin
                ready    = 1'b0;
                dir_out  = 1'b0;
                bus_keep = 1'b0;
            end
            ST_KEEP: begin
                ready    = 1'b1;
                dir_out  = 1'b1;
                bus_keep = 1'b1;
            end
            default: begin
                ready    = 1'b1;
                dir_out  = 1'b1;
                bus_keep = 1'b0;
            end
        endcase
    end

    assign start = req && ready;
endmodule

// File: rtl/bus_turnaround_gap_chk.sv
module bus_turnaround_gap_chk #(
    parameter int NUM_CS = 8,
    parameter int CNT_W  = 4,
    localparam int CS_W  = $clog2(NUM_CS)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    acc_end,
    input logic [CS_W-1:0]         end_cs,
    input logic                    end_rd,
    input logic [NUM_CS*CNT_W-1:0] turn_cnt,
    input logic                    req,
    input logic                    start,
    input logic                    ready,
    input logic                    dir_out,
    input logic                    bus_keep
);
    logic [CNT_W-1:0] chk_gap;
    assign chk_gap = turn_cnt[int'(end_cs)*CNT_W +: CNT_W];

    assert_gap_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (!dir_out && !bus_keep));

    assert_write_no_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_end && !end_rd) |=> (ready && dir_out && bus_keep));

    assert_zero_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_end && end_rd && chk_gap == '0) |=> (ready && bus_keep));

    assert_gap_begins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_end && end_rd && chk_gap != '0) |=> !ready);

    assert_gap_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (dir_out && bus_keep));

    assert_grant_rule_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ready) |-> !start);
endmodule

bind bus_turnaround_gap bus_turnaround_gap_chk #(.NUM_CS(NUM_CS), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_end  (acc_end),
    .end_cs   (end_cs),
    .end_rd   (end_rd),
    .turn_cnt (turn_cnt),
    .req      (req),
    .start    (start),
    .ready    (ready),
    .dir_out  (dir_out),
    .bus_keep (bus_keep)
);

// File: tb/bus_turnaround_gap_bench.sv
module bus_turnaround_gap_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_end = 1'b0;
    logic [2:0]  end_cs = '0;
    logic        end_rd = 1'b0;
    logic [31:0] turn_cnt;
    logic        req = 1'b0;
    logic        start, ready, dir_out, bus_keep;
    int          total = 0;
    int          bad = 0;

    // gaps: cs7=15 cs6=0 cs5=7 cs4=1 cs3=0 cs2=3 cs1=2 cs0=0
    assign turn_cnt = {4'd15, 4'd0, 4'd7, 4'd1, 4'd0, 4'd3, 4'd2, 4'd0};

    always #5 clk = ~clk;

    bus_turnaround_gap u_bus_turnaround_gap (
        .clk(clk), .rst_n(rst_n), .acc_end(acc_end), .end_cs(end_cs),
        .end_rd(end_rd), .turn_cnt(turn_cnt), .req(req), .start(start),
        .ready(ready), .dir_out(dir_out), .bus_keep(bus_keep)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic run_gap(input logic [2:0] cs, input logic rd, input int n, input string tag);
        acc_end = 1'b1; end_cs = cs; end_rd = rd;
        @(negedge clk);
        acc_end = 1'b0;
        for (int i = 0; i < n; i++) begin
            check({tag, " R2 ready low"}, ready, 1'b0);
            check({tag, " R3 dir in"}, dir_out, 1'b0);
            check({tag, " R3 keep off"}, bus_keep, 1'b0);
            @(negedge clk);
        end
        check({tag, " R4 ready back"}, ready, 1'b1);
        check({tag, " R4 dir out"}, dir_out, 1'b1);
        check({tag, " R4 keep on"}, bus_keep, 1'b1);
        @(negedge clk);
    endtask

    task automatic test_reset;
        check("R1 ready", ready, 1'b1);
        check("R1 dir", dir_out, 1'b1);
        check("R1 keep", bus_keep, 1'b0);
    endtask

    task automatic test_pending_req;
        req = 1'b1;
        acc_end = 1'b1; end_cs = 3'd2; end_rd = 1'b1;
        @(negedge clk);
        acc_end = 1'b0;
        for (int i = 0; i < 3; i++) begin
            check("R7 start held", start, 1'b0);
            @(negedge clk);
        end
        check("R7 start granted", start, 1'b1);
        req = 1'b0;
        @(negedge clk);
        check("R7 no req no start", start, 1'b0);
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        run_gap(3'd7, 1'b0, 0, "R5 write cs7");
        run_gap(3'd0, 1'b1, 0, "R6 zero-gap read cs0");
        run_gap(3'd2, 1'b1, 3, "R2 read cs2");
        run_gap(3'd5, 1'b1, 7, "R8 read cs5");
        run_gap(3'd4, 1'b1, 1, "R8 read cs4");
        run_gap(3'd7, 1'b1, 15, "R9 read cs7");
        test_pending_req();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule